// File: doc/BRIEF.md
# Dual-Width Instruction Fetch Pipeline

This block is the front end of a three-stage processor pipeline: it owns the program counter and fetches instruction memory. It passes each fetched instruction through a decode slot into an execute slot, one instruction per clock. The block runs in one of two instruction widths. In the wide state every instruction is a 32-bit word. In the compact state every instruction is a 16-bit halfword. A compact halfword is handed to execute zero-extended, with a flag so that a later stage can expand it to its 32-bit form.

The visible program counter always addresses the instruction being fetched. The instruction in the decode slot therefore sits one instruction size behind it, and the instruction in the execute slot two sizes behind. Execute steers the front end with a redirect: a target address, a valid strobe and an exchange flag. When the exchange flag is set, bit 0 of the target picks the new width. A redirect empties the two younger slots, and fetching restarts at the target.

Top module: `instr_frontend`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the wide state with `pc_out` = 0 and `ex_valid` = 0. The first valid execute instruction appears on the second clock edge after reset is released, with `ex_pc` = 0.
- R2: In the wide state (`compact_mode` = 0), each accepted fetch advances `pc_out` by 4, and `pc_out[1:0]` stays 0. The full 32-bit memory word reaches `ex_instr` with `ex_compact` = 0.
- R3: In the compact state (`compact_mode` = 1), each accepted fetch advances `pc_out` by 2, and `pc_out[0]` stays 0. `ex_instr[15:0]` carries the halfword chosen by PC bit 1 (0 selects memory bits 15:0, 1 selects bits 31:16). `ex_instr[31:16]` is 0 and `ex_compact` = 1.
- R4: Once the pipeline is full with no redirect, `ex_pc` equals `pc_out` minus twice the instruction size (8 in the wide state, 4 in the compact state).
- R5: A redirect makes `pc_out` take the aligned target on the next edge. `ex_valid` is then 0 for two cycles, and the third cycle presents the target instruction.
- R6: A redirect with `redir_xchg` = 1 sets the state from `redir_target[0]` (1 = compact, 0 = wide). The new PC is the target with bit 0 cleared in the compact state, and with bits 1:0 cleared in the wide state.
- R7: A redirect with `redir_xchg` = 0 keeps the current state. The target is aligned to that state.
- R8: A redirect takes priority over sequential fetch and over a fetch stall in the same cycle.
- R9: When `mem_rsp_valid` is 0 and there is no redirect, `pc_out` holds, and a bubble enters the decode slot. The older instruction still moves into execute.
- R10: With no redirect and no stall, one valid instruction reaches execute every clock, and consecutive `ex_pc` values differ by one instruction size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Fetch request strobe |
| mem_req_addr | output | 32 | Word-aligned fetch address |
| mem_rsp_valid | input | 1 | Memory word valid this cycle; 0 stalls the fetch |
| mem_rsp_data | input | 32 | Memory word for `mem_req_addr` |
| redir_valid | input | 1 | Redirect strobe from execute |
| redir_target | input | 32 | Redirect destination |
| redir_xchg | input | 1 | Redirect also selects the state from target bit 0 |
| pc_out | output | 32 | Fetch program counter |
| compact_mode | output | 1 | 1 = 16-bit state, 0 = 32-bit state |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_instr | output | 32 | Execute instruction (compact: zero-extended halfword) |
| ex_pc | output | 32 | Address of the execute instruction |
| ex_compact | output | 1 | Execute instruction needs expansion |

## Verification
The hardest case to reach from the ports combines three conditions in one cycle: a redirect, a memory stall, and a width change. This checks that the redirect wins and that the discarded fetch never reaches execute. A second hard case is a compact fetch at an address with PC bit 1 set. It can only be reached through an exchange redirect to an odd target, followed by sequential fetch. The stimulus table places a stall, exchange redirects to odd and even targets, and a non-exchange redirect to a misaligned target back to back. Each cycle is compared against a behavioural model of the three slots.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int XLEN = 32;
    localparam int HALF = XLEN / 2;
    localparam int WIDE_BYTES = XLEN / 8;
    localparam int CMPT_BYTES = HALF / 8;

    typedef logic [XLEN-1:0] addr_t;
    typedef logic [XLEN-1:0] word_t;

    typedef enum logic {
        ST_WIDE    = 1'b0,
        ST_COMPACT = 1'b1
    } istate_e;

    typedef struct packed {
        logic  valid;
        logic  compact;
        addr_t pc;
        word_t instr;
    } slot_t;

    function automatic addr_t step_of(istate_e st);
        return (st == ST_COMPACT) ? addr_t'(CMPT_BYTES) : addr_t'(WIDE_BYTES);
    endfunction

    function automatic addr_t align_pc(addr_t a, istate_e st);
        addr_t r;
        r = a;
        r[0] = 1'b0;
        if (st == ST_WIDE) r[1] = 1'b0;
        return r;
    endfunction

    function automatic addr_t word_addr(addr_t a);
        addr_t r;
        r = a;
        r[1:0] = 2'b00;
        return r;
    endfunction

    function automatic word_t pick_instr(word_t w, logic hi_sel, istate_e st);
        word_t r;
        if (st == ST_COMPACT) begin
            r = '0;
            r[HALF-1:0] = hi_sel ? w[XLEN-1:HALF] : w[HALF-1:0];
        end else begin
            r = w;
        end
        return r;
    endfunction

endpackage

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import fetch_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    advance,
    input  logic    redir_valid,
    input  addr_t   redir_target,
    input  logic    redir_xchg,
    output addr_t   pc,
    output istate_e state
);

    istate_e next_state;

    always_comb begin
        next_state = state;
        if (redir_xchg) next_state = istate_e'(redir_target[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= RESET_PC;
            state <= ST_WIDE;
        end else if (redir_valid) begin
            state <= next_state;
            pc    <= align_pc(redir_target, next_state);
        end else if (advance) begin
            pc <= pc + step_of(state);
        end
    end

endmodule

// File: rtl/fetch_align.sv
module fetch_align
    import fetch_pkg::*;
(
    input  logic    rsp_valid,
    input  word_t   rsp_word,
    input  addr_t   pc,
    input  istate_e state,
    output slot_t   slot
);

    always_comb begin
        slot.valid   = rsp_valid;
        slot.compact = (state == ST_COMPACT);
        slot.pc      = pc;
        slot.instr   = pick_instr(rsp_word, pc[1], state);
    end

endmodule

// File: rtl/fetch_slot_reg.sv
module fetch_slot_reg
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t d,
    output slot_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/instr_frontend.sv
module instr_frontend
    import fetch_pkg::*;
#(
    parameter addr_t RESET_PC   = '0,
    parameter int    NUM_SLOTS  = 2
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_req_valid,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    input  logic            redir_valid,
    input  logic [XLEN-1:0] redir_target,
    input  logic            redir_xchg,
    output logic [XLEN-1:0] pc_out,
    output logic            compact_mode,
    output logic            ex_valid,
    output logic [XLEN-1:0] ex_instr,
    output logic [XLEN-1:0] ex_pc,
    output logic            ex_compact
);

    localparam int LAST = NUM_SLOTS;

    addr_t   pc;
    istate_e state;
    slot_t   chain [LAST+1];

    fetch_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
        .clk          (clk),
        .rst          (rst),
        .advance      (mem_rsp_valid),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .redir_xchg   (redir_xchg),
        .pc           (pc),
        .state        (state)
    );

    fetch_align u_align (
        .rsp_valid (mem_rsp_valid),
        .rsp_word  (mem_rsp_data),
        .pc        (pc),
        .state     (state),
        .slot      (chain[0])
    );

    // decode slot and execute slot; a redirect empties both
    for (genvar k = 0; k < LAST; k++) begin : g_slot
        fetch_slot_reg u_slot (
            .clk   (clk),
            .rst   (rst),
            .flush (redir_valid),
            .d     (chain[k]),
            .q     (chain[k+1])
        );
    end

    assign mem_req_valid = !rst;
    assign mem_req_addr  = word_addr(pc);
    assign pc_out        = pc;
    assign compact_mode  = (state == ST_COMPACT);
    assign ex_valid      = chain[LAST].valid;
    assign ex_instr      = chain[LAST].instr;
    assign ex_pc         = chain[LAST].pc;
    assign ex_compact    = chain[LAST].compact;

endmodule

// File: rtl/instr_frontend_chk.sv
module instr_frontend_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rsp_valid,
    input logic        redir_valid,
    input logic [31:0] redir_target,
    input logic        redir_xchg,
    input logic [31:0] pc_out,
    input logic        compact_mode,
    input logic        ex_valid
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc_out == 32'h0 && !compact_mode && !ex_valid));

    // R2
    wide_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && mem_rsp_valid && !compact_mode) |=> pc_out == $past(pc_out) + 32'd4);

    // R3
    compact_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && mem_rsp_valid && compact_mode) |=> pc_out == $past(pc_out) + 32'd2);

    // R2
    wide_align_chk: assert property (@(posedge clk) disable iff (rst)
        !compact_mode |-> pc_out[1:0] == 2'b00);

    // R3
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc_out[0] == 1'b0);

    // R5
    redir_target_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> pc_out[31:2] == $past(redir_target[31:2]));

    // R5
    redir_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !ex_valid);

    // R6
    xchg_state_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && redir_xchg) |=> compact_mode == $past(redir_target[0]));

    // R7
    keep_state_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !redir_xchg) |=> $stable(compact_mode));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && !mem_rsp_valid) |=> $stable(pc_out));

endmodule

bind instr_frontend instr_frontend_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_rsp_valid (mem_rsp_valid),
    .redir_valid   (redir_valid),
    .redir_target  (redir_target),
    .redir_xchg    (redir_xchg),
    .pc_out        (pc_out),
    .compact_mode  (compact_mode),
    .ex_valid      (ex_valid)
);

// File: tb/instr_frontend_tb.sv
`timescale 1ns/1ps
module instr_frontend_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b1;
    logic [31:0] mem_rsp_data;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_target = '0;
    logic        redir_xchg = 1'b0;
    logic [31:0] pc_out;
    logic        compact_mode;
    logic        ex_valid;
    logic [31:0] ex_instr;
    logic [31:0] ex_pc;
    logic        ex_compact;

    always #4 clk = ~clk;

    // memory: halves tagged B (upper) and C (lower) with the word index
    assign mem_rsp_data = {4'hB, mem_req_addr[13:2], 4'hC, mem_req_addr[13:2]};

    instr_frontend u_dut (
        .clk(clk), .rst(rst),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .redir_valid(redir_valid), .redir_target(redir_target), .redir_xchg(redir_xchg),
        .pc_out(pc_out), .compact_mode(compact_mode),
        .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_pc(ex_pc), .ex_compact(ex_compact)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {4'hB, a[13:2], 4'hC, a[13:2]};
    endfunction

    function automatic logic [31:0] exp_instr(input logic [31:0] a, input logic cm);
        logic [31:0] w;
        w = mem_word(a);
        if (!cm) return w;
        return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    endfunction

    // behavioural model of PC, state and the two slots
    logic [31:0] m_pc;
    logic        m_cm;
    logic        d_v, e_v, d_c, e_c;
    logic [31:0] d_pc, e_pc, d_i, e_i;

    task automatic model_reset();
        m_pc = 0; m_cm = 0; d_v = 0; e_v = 0;
        d_c = 0; e_c = 0; d_pc = 0; e_pc = 0; d_i = 0; e_i = 0;
    endtask

    task automatic model_step(input logic rv, input logic xg, input logic [31:0] tg, input logic ok);
        if (rv) begin
            d_v = 0; e_v = 0;
            if (xg) m_cm = tg[0];
            m_pc = tg & (m_cm ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
        end else begin
            e_v = d_v; e_pc = d_pc; e_i = d_i; e_c = d_c;
            d_v = ok;
            if (ok) begin
                d_pc = m_pc; d_c = m_cm; d_i = exp_instr(m_pc, m_cm);
                m_pc = m_pc + (m_cm ? 32'd2 : 32'd4);
            end
        end
    endtask

    // {tag, redirect, exchange, response ok, target}
    localparam int NV = 30;
    localparam logic [38:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd9, 1'b0, 1'b0, 1'b0, 32'h0}, {4'd9, 1'b0, 1'b0, 1'b0, 32'h0},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd6, 1'b1, 1'b1, 1'b1, 32'h0000_0103},
        {4'd3, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd3, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd3, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd3, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd9, 1'b0, 1'b0, 1'b0, 32'h0}, {4'd3, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd7, 1'b1, 1'b0, 1'b1, 32'h0000_0207},
        {4'd3, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd3, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd3, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd8, 1'b1, 1'b1, 1'b0, 32'h0000_0040},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd7, 1'b1, 1'b0, 1'b1, 32'h0000_0087},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd6, 1'b1, 1'b1, 1'b1, 32'h0000_0056},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}, {4'd2, 1'b0, 1'b0, 1'b1, 32'h0},
        {4'd2, 1'b0, 1'b0, 1'b1, 32'h0}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic compare_model(input string tg);
        chk(tg, "pc_out", pc_out, m_pc);
        chk(tg, "compact_mode", {31'h0, compact_mode}, {31'h0, m_cm});
        chk("R5", "ex_valid", {31'h0, ex_valid}, {31'h0, e_v});
        if (e_v) begin
            chk("R4", "ex_pc", ex_pc, e_pc);
            chk(e_c ? "R3" : "R2", "ex_instr", ex_instr, e_i);
            chk(e_c ? "R3" : "R2", "ex_compact", {31'h0, ex_compact}, {31'h0, e_c});
        end
    endtask

    initial begin
        logic [31:0] prev_pc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: state right after reset
        chk("R1", "pc_out after reset", pc_out, 32'h0);
        chk("R1", "ex_valid after reset", {31'h0, ex_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                @(negedge clk);
                compare_model(tag_name(VEC[i-1][38:35]));
            end
            redir_valid   = VEC[i][34];
            redir_xchg    = VEC[i][33];
            mem_rsp_valid = VEC[i][32];
            redir_target  = VEC[i][31:0];
            model_step(VEC[i][34], VEC[i][33], VEC[i][31:0], VEC[i][32]);
        end
        @(negedge clk);
        compare_model(tag_name(VEC[NV-1][38:35]));
        redir_valid = 1'b0; mem_rsp_valid = 1'b1;

        // R10 and R4: full wide pipeline, one instruction per clock
        repeat (3) @(negedge clk);
        prev_pc = ex_pc;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R10", "ex_valid streaming", {31'h0, ex_valid}, 32'h1);
            chk("R10", "ex_pc step", ex_pc, prev_pc + 32'd4);
            chk("R4", "pc_out minus ex_pc", pc_out - ex_pc, 32'd8);
            prev_pc = ex_pc;
        end

        // R3 and R4: compact halfword selection at an address with bit 1 set
        redir_valid = 1'b1; redir_xchg = 1'b1; redir_target = 32'h0000_0303;
        @(negedge clk);
        redir_valid = 1'b0;
        chk("R6", "pc after odd exchange", pc_out, 32'h0000_0302);
        @(negedge clk);
        chk("R5", "first bubble", {31'h0, ex_valid}, 32'h0);
        @(negedge clk);
        chk("R3", "upper halfword", ex_instr, {16'h0, 4'hB, 12'h0C0});
        chk("R4", "compact offset", pc_out - ex_pc, 32'd4);
        @(negedge clk);
        chk("R3", "lower halfword", ex_instr, {16'h0, 4'hC, 12'h0C1});

        // R1: reset mid-run, then the first instruction arrives on the second edge
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "pc_out in reset", pc_out, 32'h0);
        chk("R1", "state in reset", {31'h0, compact_mode}, 32'h0);
        chk("R1", "ex_valid in reset", {31'h0, ex_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ex_valid one edge after reset", {31'h0, ex_valid}, 32'h0);
        @(negedge clk);
        chk("R1", "ex_valid two edges after reset", {31'h0, ex_valid}, 32'h1);
        chk("R1", "first ex_pc", ex_pc, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule